// File: doc/BRIEF.md
# Page-Mapped Dual Cache Dispatcher

This block sits between a processor load/store port and two data caches that share one level of the hierarchy: a large main cache without error protection and a small mini cache guarded by an error-correcting code. Memory is split into fixed 1 KB pages. A table holds one bit per page that software sets through a configuration port. The bit marks the page as critical (control data such as loop counters, loop limits and branch conditions) or non-critical (bulk media samples). Each access is sent to exactly one cache, chosen by the bit of the page it falls in. Critical pages go to the protected mini cache and the rest go to the main cache.

Only one request is in flight at a time. The processor port is stalled until the selected cache answers, and that answer is passed back to the processor. Responses from the other cache, or responses that arrive while nothing is in flight, are dropped. The block keeps per-cache access and miss counters and a running cycle estimate. Each access adds 2 cycles to the estimate and each miss adds 25. Every table entry resets to critical, so data that software has not classified is protected by default.

Top module: `page_dual_cache_dispatch`

## Requirements
- R1: After reset every page is critical, all four counters and the cycle estimate read zero, the processor port is ready, and no cache request is raised.
- R2: The page index is address bits [15:10] (the address shifted right by 10). Offset bits [9:0] never change the routing, and two neighbouring pages route by their own bits.
- R3: An accepted request raises the request valid of exactly one cache: the mini cache when the page bit is 1 (critical) and the main cache when it is 0. Address, write flag and write data are forwarded unchanged.
- R4: A configuration write stores bit cfg_crit for page cfg_page. It routes every request accepted after that write's clock edge. A request accepted in the same cycle as the write still uses the old bit. A page can be switched either way.
- R5: Once a request is accepted, cpu_req_ready stays low and no further cache request is raised until the selected cache responds. Ready returns high in the cycle after that response.
- R6: A response from the selected cache, while a request is in flight, appears on cpu_rsp_valid and cpu_rsp_rdata in the same cycle. A response from the other cache, or any response while idle, gives no processor response and changes no counter.
- R7: A change to the page bit while a request is in flight does not reroute that request. Its completion still comes from the cache chosen at acceptance.
- R8: Each cache's access counter increments by one for every request dispatched to that cache.
- R9: Each cache's miss counter increments by one for every accepted response from that cache that has its miss flag set.
- R10: The cycle estimate grows by 2 for each dispatched access and by 25 for each counted miss, summed over both caches, and is otherwise unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Page bit write strobe |
| cfg_page | input | 6 | Page index to write |
| cfg_crit | input | 1 | New bit: 1 critical, 0 non-critical |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_ready | output | 1 | Dispatcher can accept a request |
| cpu_req_addr | input | 16 | Byte address |
| cpu_req_we | input | 1 | Write access |
| cpu_req_wdata | input | 32 | Write data |
| cpu_rsp_valid | output | 1 | Response to processor |
| cpu_rsp_rdata | output | 32 | Read data to processor |
| main_req_valid | output | 1 | Request to main cache |
| main_req_addr | output | 16 | Address to main cache |
| main_req_we | output | 1 | Write flag to main cache |
| main_req_wdata | output | 32 | Write data to main cache |
| main_rsp_valid | input | 1 | Main cache response |
| main_rsp_rdata | input | 32 | Main cache read data |
| main_rsp_miss | input | 1 | Main cache response was a miss |
| mini_req_valid | output | 1 | Request to mini cache |
| mini_req_addr | output | 16 | Address to mini cache |
| mini_req_we | output | 1 | Write flag to mini cache |
| mini_req_wdata | output | 32 | Write data to mini cache |
| mini_rsp_valid | input | 1 | Mini cache response |
| mini_rsp_rdata | input | 32 | Mini cache read data |
| mini_rsp_miss | input | 1 | Mini cache response was a miss |
| main_acc_cnt | output | 32 | Main cache access count |
| main_miss_cnt | output | 32 | Main cache miss count |
| mini_acc_cnt | output | 32 | Mini cache access count |
| mini_miss_cnt | output | 32 | Mini cache miss count |
| cycle_est | output | 40 | Accumulated cycle estimate |

## Verification
Two functions can fall in the same cycle: a configuration write to a page and the acceptance of a request to that page. The bench drives both in one cycle and checks that the request goes to the cache given by the old bit, and that the next request to the page follows the new bit. A page bit can also change while a request is in flight, in the same cycle as a stray response from the other cache. That case is judged by the processor response staying low and the miss counters holding until the originally selected cache answers.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  // Cache target; value equals the page criticality bit
  typedef enum logic {
    TGT_MAIN = 1'b0,
    TGT_MINI = 1'b1
  } tgt_e;
endpackage

// File: rtl/page_attr_table.sv
module page_attr_table #(
  parameter int PG_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [PG_W-1:0] wr_idx,
  input  logic            wr_crit,
  input  logic [PG_W-1:0] rd_idx,
  output logic            rd_crit
);
  localparam int NUM_PAGES = 1 << PG_W;

  logic [NUM_PAGES-1:0] attr_q;
  logic [NUM_PAGES-1:0] attr_d;

  for (genvar g = 0; g < NUM_PAGES; g++) begin : g_entry
    always_comb begin
      attr_d[g] = attr_q[g];
      if (wr_en && (wr_idx == PG_W'(g))) attr_d[g] = wr_crit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) attr_q[g] <= 1'b1;
      else        attr_q[g] <= attr_d[g];
    end
  end

  // read sees the registered value: a same-cycle write is not visible
  assign rd_crit = attr_q[rd_idx];
endmodule

// File: rtl/route_ctrl.sv
module route_ctrl
  import pdc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_fire,
  input  tgt_e req_tgt,
  input  logic main_rsp_v,
  input  logic mini_rsp_v,
  output logic busy,
  output tgt_e sel_tgt,
  output logic done_main,
  output logic done_mini
);
  logic busy_d;
  tgt_e sel_d;

  assign done_main = busy && (sel_tgt == TGT_MAIN) && main_rsp_v;
  assign done_mini = busy && (sel_tgt == TGT_MINI) && mini_rsp_v;

  always_comb begin
    busy_d = busy;
    sel_d  = sel_tgt;
    if (req_fire) begin
      busy_d = 1'b1;
      sel_d  = req_tgt;
    end else if (done_main || done_mini) begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      sel_tgt <= TGT_MAIN;
    end else begin
      busy    <= busy_d;
      sel_tgt <= sel_d;
    end
  end
endmodule

// File: rtl/perf_counters.sv
module perf_counters #(
  parameter int CNT_W     = 32,
  parameter int CYC_W     = 40,
  parameter int ACC_COST  = 2,
  parameter int MISS_COST = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_main,
  input  logic             acc_mini,
  input  logic             miss_main,
  input  logic             miss_mini,
  output logic [CNT_W-1:0] main_acc,
  output logic [CNT_W-1:0] main_miss,
  output logic [CNT_W-1:0] mini_acc,
  output logic [CNT_W-1:0] mini_miss,
  output logic [CYC_W-1:0] cyc_est
);
  localparam int NCNT = 4;
  localparam logic [CYC_W-1:0] ACC_INC  = CYC_W'(ACC_COST);
  localparam logic [CYC_W-1:0] MISS_INC = CYC_W'(MISS_COST);

  logic [NCNT-1:0]  cnt_en;
  logic [CNT_W-1:0] cnt_q [NCNT];
  logic [CYC_W-1:0] cyc_d;
  logic             cyc_en;

  assign cnt_en = {miss_mini, acc_mini, miss_main, acc_main};

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q[g] <= '0;
      else if (cnt_en[g]) cnt_q[g] <= cnt_q[g] + 1'b1;
    end
  end

  always_comb begin
    cyc_d = cyc_est;
    if (acc_main || acc_mini)   cyc_d = cyc_d + ACC_INC;
    if (miss_main || miss_mini) cyc_d = cyc_d + MISS_INC;
  end
  assign cyc_en = |cnt_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cyc_est <= '0;
    else if (cyc_en) cyc_est <= cyc_d;
  end

  assign main_acc  = cnt_q[0];
  assign main_miss = cnt_q[1];
  assign mini_acc  = cnt_q[2];
  assign mini_miss = cnt_q[3];
endmodule

// File: rtl/page_dual_cache_dispatch.sv
module page_dual_cache_dispatch
  import pdc_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int OFS_W     = 10,
  parameter int CNT_W     = 32,
  parameter int CYC_W     = 40,
  parameter int ACC_COST  = 2,
  parameter int MISS_COST = 25,
  localparam int PG_W     = ADDR_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [PG_W-1:0]   cfg_page,
  input  logic              cfg_crit,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic              cpu_req_we,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              main_req_valid,
  output logic [ADDR_W-1:0] main_req_addr,
  output logic              main_req_we,
  output logic [DATA_W-1:0] main_req_wdata,
  input  logic              main_rsp_valid,
  input  logic [DATA_W-1:0] main_rsp_rdata,
  input  logic              main_rsp_miss,
  output logic              mini_req_valid,
  output logic [ADDR_W-1:0] mini_req_addr,
  output logic              mini_req_we,
  output logic [DATA_W-1:0] mini_req_wdata,
  input  logic              mini_rsp_valid,
  input  logic [DATA_W-1:0] mini_rsp_rdata,
  input  logic              mini_rsp_miss,
  output logic [CNT_W-1:0]  main_acc_cnt,
  output logic [CNT_W-1:0]  main_miss_cnt,
  output logic [CNT_W-1:0]  mini_acc_cnt,
  output logic [CNT_W-1:0]  mini_miss_cnt,
  output logic [CYC_W-1:0]  cycle_est
);
  logic [PG_W-1:0] page_idx;
  logic            page_crit;
  tgt_e            route;
  logic            req_fire;
  logic            busy;
  tgt_e            sel_tgt;
  logic            done_main;
  logic            done_mini;

  assign page_idx = cpu_req_addr[ADDR_W-1:OFS_W];

  page_attr_table #(.PG_W(PG_W)) attr_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_idx  (cfg_page),
    .wr_crit (cfg_crit),
    .rd_idx  (page_idx),
    .rd_crit (page_crit)
  );

  assign route         = page_crit ? TGT_MINI : TGT_MAIN;
  assign cpu_req_ready = !busy;
  assign req_fire      = cpu_req_valid && !busy;

  route_ctrl ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_fire   (req_fire),
    .req_tgt    (route),
    .main_rsp_v (main_rsp_valid),
    .mini_rsp_v (mini_rsp_valid),
    .busy       (busy),
    .sel_tgt    (sel_tgt),
    .done_main  (done_main),
    .done_mini  (done_mini)
  );

  assign main_req_valid = req_fire && (route == TGT_MAIN);
  assign mini_req_valid = req_fire && (route == TGT_MINI);
  assign main_req_addr  = cpu_req_addr;
  assign mini_req_addr  = cpu_req_addr;
  assign main_req_we    = cpu_req_we;
  assign mini_req_we    = cpu_req_we;
  assign main_req_wdata = cpu_req_wdata;
  assign mini_req_wdata = cpu_req_wdata;

  assign cpu_rsp_valid = done_main || done_mini;
  assign cpu_rsp_rdata = (sel_tgt == TGT_MINI) ? mini_rsp_rdata : main_rsp_rdata;

  perf_counters #(
    .CNT_W(CNT_W), .CYC_W(CYC_W), .ACC_COST(ACC_COST), .MISS_COST(MISS_COST)
  ) perf_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_main  (main_req_valid),
    .acc_mini  (mini_req_valid),
    .miss_main (done_main && main_rsp_miss),
    .miss_mini (done_mini && mini_rsp_miss),
    .main_acc  (main_acc_cnt),
    .main_miss (main_miss_cnt),
    .mini_acc  (mini_acc_cnt),
    .mini_miss (mini_miss_cnt),
    .cyc_est   (cycle_est)
  );
endmodule

// File: rtl/pdc_checker.sv
module pdc_checker #(
  parameter int CNT_W = 32,
  parameter int CYC_W = 40
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_req_ready,
  input logic             cpu_rsp_valid,
  input logic             main_req_valid,
  input logic             mini_req_valid,
  input logic [CNT_W-1:0] main_acc_cnt,
  input logic [CNT_W-1:0] mini_acc_cnt,
  input logic [CYC_W-1:0] cycle_est
);
  assert_one_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(main_req_valid && mini_req_valid));

  assert_stall_after_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (main_req_valid || mini_req_valid) |=> !cpu_req_ready);

  assert_no_dispatch_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_req_ready |-> !(main_req_valid || mini_req_valid));

  assert_rsp_only_in_flight_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |-> !cpu_req_ready);

  assert_ready_after_rsp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |=> cpu_req_ready);

  assert_main_acc_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    main_req_valid |=> main_acc_cnt == $past(main_acc_cnt) + 1'b1);

  assert_mini_acc_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mini_req_valid |=> mini_acc_cnt == $past(mini_acc_cnt) + 1'b1);

  assert_cycle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!main_req_valid && !mini_req_valid && !cpu_rsp_valid) |=> $stable(cycle_est));
endmodule

bind page_dual_cache_dispatch pdc_checker #(.CNT_W(CNT_W), .CYC_W(CYC_W)) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .cpu_req_ready  (cpu_req_ready),
  .cpu_rsp_valid  (cpu_rsp_valid),
  .main_req_valid (main_req_valid),
  .mini_req_valid (mini_req_valid),
  .main_acc_cnt   (main_acc_cnt),
  .mini_acc_cnt   (mini_acc_cnt),
  .cycle_est      (cycle_est)
);

// File: tb/page_dual_cache_dispatch_tb_top.sv
`timescale 1ns/1ps
module page_dual_cache_dispatch_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_crit;
  logic [5:0]  cfg_page;
  logic        cpu_req_valid, cpu_req_ready, cpu_req_we;
  logic [15:0] cpu_req_addr;
  logic [31:0] cpu_req_wdata, cpu_rsp_rdata;
  logic        cpu_rsp_valid;
  logic        main_req_valid, main_req_we, mini_req_valid, mini_req_we;
  logic [15:0] main_req_addr, mini_req_addr;
  logic [31:0] main_req_wdata, mini_req_wdata;
  logic        main_rsp_valid, main_rsp_miss, mini_rsp_valid, mini_rsp_miss;
  logic [31:0] main_rsp_rdata, mini_rsp_rdata;
  logic [31:0] main_acc_cnt, main_miss_cnt, mini_acc_cnt, mini_miss_cnt;
  logic [39:0] cycle_est;

  int total = 0;
  int bad   = 0;
  longint e_main_acc = 0, e_main_miss = 0, e_mini_acc = 0, e_mini_miss = 0, e_cyc = 0;

  always #10 clk = ~clk;

  page_dual_cache_dispatch dut_i (.*);

  task automatic chk(input string rq, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic chk_counters(input string rq);
    chk({rq, " main_acc"},  longint'(main_acc_cnt),  e_main_acc);
    chk({rq, " main_miss"}, longint'(main_miss_cnt), e_main_miss);
    chk({rq, " mini_acc"},  longint'(mini_acc_cnt),  e_mini_acc);
    chk({rq, " mini_miss"}, longint'(mini_miss_cnt), e_mini_miss);
    chk({rq, " cycle_est"}, longint'(cycle_est),     e_cyc);
  endtask

  task automatic cfg_write(input logic [5:0] pg, input logic crit);
    @(negedge clk);
    cfg_we = 1'b1; cfg_page = pg; cfg_crit = crit;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic respond(input logic to_mini, input logic miss, input logic [31:0] rd);
    if (to_mini) begin
      mini_rsp_valid = 1'b1; mini_rsp_miss = miss; mini_rsp_rdata = rd;
      e_mini_miss += miss;
    end else begin
      main_rsp_valid = 1'b1; main_rsp_miss = miss; main_rsp_rdata = rd;
      e_main_miss += miss;
    end
    if (miss) e_cyc += 25;
  endtask

  task automatic clear_rsp();
    main_rsp_valid = 1'b0; main_rsp_miss = 1'b0;
    mini_rsp_valid = 1'b0; mini_rsp_miss = 1'b0;
  endtask

  // full access: dispatch, stall, response, counter update
  task automatic do_access(input logic [15:0] addr, input logic exp_mini,
                           input logic miss, input logic [31:0] rd, input string rq);
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_addr = addr;
    cpu_req_we = addr[0]; cpu_req_wdata = {16'hA5A5, addr};
    #1;
    chk({rq, " R5 ready"}, cpu_req_ready, 1);
    chk({rq, " R3 main_req"}, main_req_valid, !exp_mini);
    chk({rq, " R3 mini_req"}, mini_req_valid, exp_mini);
    chk({rq, " R3 addr"}, exp_mini ? mini_req_addr : main_req_addr, addr);
    chk({rq, " R3 wdata"}, exp_mini ? mini_req_wdata : main_req_wdata, {16'hA5A5, addr});
    chk({rq, " R3 we"}, exp_mini ? mini_req_we : main_req_we, addr[0]);
    if (exp_mini) e_mini_acc++; else e_main_acc++;
    e_cyc += 2;
    @(negedge clk);
    cpu_req_valid = 1'b0;
    #1;
    chk({rq, " R5 stall"}, cpu_req_ready, 0);
    respond(exp_mini, miss, rd);
    #1;
    chk({rq, " R6 rsp_valid"}, cpu_rsp_valid, 1);
    chk({rq, " R6 rdata"}, cpu_rsp_rdata, rd);
    @(negedge clk);
    clear_rsp();
    #1;
    chk({rq, " R5 ready back"}, cpu_req_ready, 1);
    chk_counters({rq, " R8 R9 R10"});
  endtask

  task automatic t_reset();
    #1;
    chk("R1 ready", cpu_req_ready, 1);
    chk("R1 no main req", main_req_valid, 0);
    chk("R1 no mini req", mini_req_valid, 0);
    chk_counters("R1 counters");
  endtask

  task automatic t_default_critical();
    do_access(16'h0000, 1'b1, 1'b0, 32'h1111_0000, "R1 page0 default");
    do_access(16'hFC04, 1'b1, 1'b1, 32'h1111_003F, "R1 page63 default");
  endtask

  task automatic t_page_boundary();
    cfg_write(6'd1, 1'b0);
    do_access(16'h0400, 1'b0, 1'b0, 32'h2222_0001, "R2 page1 low");
    do_access(16'h07FF, 1'b0, 1'b1, 32'h2222_0002, "R2 page1 high");
    do_access(16'h0800, 1'b1, 1'b0, 32'h2222_0003, "R2 page2 low");
    do_access(16'h03FF, 1'b1, 1'b1, 32'h2222_0004, "R2 page0 high");
  endtask

  task automatic t_remark();
    cfg_write(6'd1, 1'b1);
    do_access(16'h0510, 1'b1, 1'b1, 32'h3333_0001, "R4 page1 back to critical");
  endtask

  task automatic t_stray_idle();
    @(negedge clk);
    main_rsp_valid = 1'b1; main_rsp_miss = 1'b1; main_rsp_rdata = 32'hDEAD;
    mini_rsp_valid = 1'b1; mini_rsp_miss = 1'b1; mini_rsp_rdata = 32'hBEEF;
    #1;
    chk("R6 idle stray rsp", cpu_rsp_valid, 0);
    @(negedge clk);
    clear_rsp();
    #1;
    chk("R6 idle ready", cpu_req_ready, 1);
    chk_counters("R6 idle counters");
  endtask

  task automatic t_inflight();
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_addr = 16'h1400; cpu_req_we = 1'b0; cpu_req_wdata = '0;
    #1;
    chk("R7 dispatch mini", mini_req_valid, 1);
    e_mini_acc++; e_cyc += 2;
    @(negedge clk);
    cpu_req_valid = 1'b0;
    cfg_we = 1'b1; cfg_page = 6'd5; cfg_crit = 1'b0;
    main_rsp_valid = 1'b1; main_rsp_miss = 1'b1; main_rsp_rdata = 32'hBAD0;
    #1;
    chk("R6 other cache rsp ignored", cpu_rsp_valid, 0);
    chk("R7 still busy", cpu_req_ready, 0);
    @(negedge clk);
    cfg_we = 1'b0;
    clear_rsp();
    #1;
    chk("R7 still busy after stray", cpu_req_ready, 0);
    chk("R6 main miss unchanged", longint'(main_miss_cnt), e_main_miss);
    respond(1'b1, 1'b0, 32'h4444_0005);
    #1;
    chk("R7 rsp from mini", cpu_rsp_valid, 1);
    chk("R7 rdata from mini", cpu_rsp_rdata, 32'h4444_0005);
    @(negedge clk);
    clear_rsp();
    #1;
    chk_counters("R7 counters");
    do_access(16'h17F0, 1'b0, 1'b1, 32'h4444_0006, "R4 page5 now main");
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_addr = 16'h1C20; cpu_req_we = 1'b1; cpu_req_wdata = 32'h77;
    cfg_we = 1'b1; cfg_page = 6'd7; cfg_crit = 1'b0;
    #1;
    chk("R4 same-cycle uses old bit mini", mini_req_valid, 1);
    chk("R4 same-cycle not main", main_req_valid, 0);
    e_mini_acc++; e_cyc += 2;
    @(negedge clk);
    cpu_req_valid = 1'b0; cfg_we = 1'b0;
    respond(1'b1, 1'b1, 32'h5555_0007);
    #1;
    chk("R6 same-cycle rsp", cpu_rsp_valid, 1);
    @(negedge clk);
    clear_rsp();
    #1;
    chk_counters("R4 same-cycle counters");
    do_access(16'h1C24, 1'b0, 1'b0, 32'h5555_0008, "R4 page7 new bit main");
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_we = 1'b0; cfg_page = '0; cfg_crit = 1'b0;
    cpu_req_valid = 1'b0; cpu_req_addr = '0; cpu_req_we = 1'b0; cpu_req_wdata = '0;
    main_rsp_rdata = '0; mini_rsp_rdata = '0;
    clear_rsp();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_default_critical();
    t_page_boundary();
    t_remark();
    t_stray_idle();
    t_inflight();
    t_same_cycle();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule